// File: doc/BRIEF.md
# Dual-Enable Bidirectional Latched Transceiver

This block moves data between two byte-wide sides, called A and B, in each of several independent sections (two sections of eight bits by default). Each direction of each section owns its own storage bank and three active-low controls: a direction enable, a latch enable and an output enable. The enable and the latch enable together choose between a transparent path and a held value. The enable and the output enable together decide whether the far side is driven.

Pins are modelled as separate input vectors, output vectors and one drive flag per section and side, instead of tri-state wires. The storage is clocked. A bank loads its input on every rising clock edge at which its path is transparent. While the path is transparent, the output shows the live input without waiting for an edge. Once either the enable or the latch enable rises, the bank keeps the value it took at the last transparent edge. An asynchronous active-low power-up reset clears every bank and releases every output.

These pins carry no stream traffic, so there is no valid/ready handshake and no back-pressure: every pin is a plain level.

Top module: `dual_latch_xcvr`

## Requirements
- R1: Each section responds only to its own controls and data. Activity in one section never alters another section's outputs or stored values.
- R2: When a direction's enable and latch enable are both low, its output shows the current input in the same cycle, and its bank loads that input at each rising clock edge.
- R3: After the latch enable or the enable goes high, the bank keeps the input value sampled at the last edge at which the path was transparent. Later input changes do not affect it.
- R4: With the enable low and the latch enable high, the bank's contents stay unchanged, and the output shows them when driven.
- R5: A side's drive flag is high only while that direction's output enable and enable are both low (and reset is inactive). If either control is high, the flag is low.
- R6: A value captured while the output is released appears on the output as soon as the output enable and the enable are both low.
- R7: The A-to-B and B-to-A banks of one section are separate and can hold different values at the same time.
- R8: While reset is low, every drive flag is low. After reset, every bank reads zero.
- R9: Whenever a side's drive flag is low, that side's data output is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Storage clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| a_in | input | 16 | Data arriving on the A side, byte per section |
| b_in | input | 16 | Data arriving on the B side, byte per section |
| a_out | output | 16 | Data driven onto the A side (B-to-A path) |
| b_out | output | 16 | Data driven onto the B side (A-to-B path) |
| a_drive | output | 2 | Per-section A side drive flag |
| b_drive | output | 2 | Per-section B side drive flag |
| ab_en_n | input | 2 | A-to-B enable per section, active low |
| ab_le_n | input | 2 | A-to-B latch enable per section, active low |
| ab_oe_n | input | 2 | A-to-B output enable per section, active low |
| ba_en_n | input | 2 | B-to-A enable per section, active low |
| ba_le_n | input | 2 | B-to-A latch enable per section, active low |
| ba_oe_n | input | 2 | B-to-A output enable per section, active low |

## Verification
A sweep walks all 64 combinations of the six controls of each section with changing data. This separates transparent, holding and released states and shows whether the enable acts on both the storage and the drive. A pseudo-random phase then exercises longer histories, where a wrong capture edge shows up as a stale or early byte. Directed sequences cover the cases the sweep can blur: capture through the enable instead of the latch enable, capture while the output is released, different values held in the two directions, a quiet section next to a busy one, and contents cleared by reset. Stimulus never makes both directions of one section transparent and driving at once, and a monitor in the bench counts any case where that happens.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic en_n;
    logic le_n;
    logic oe_n;
  } dir_ctrl_t;
endpackage

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_ctrl_t        ctrl,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);
  logic [WIDTH-1:0] bank_q;
  logic             pass_thru;

  assign pass_thru = !ctrl.en_n && !ctrl.le_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         bank_q <= '0;
    else if (pass_thru) bank_q <= din;
  end

  assign drive = rst_n && !ctrl.oe_n && !ctrl.en_n;
  assign dout  = drive ? (pass_thru ? din : bank_q) : '0;

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en_n && !ctrl.le_n) |=> (bank_q == $past(din)));

  // R4
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en_n || ctrl.le_n) |=> $stable(bank_q));

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.oe_n || ctrl.en_n) |-> !drive);

  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drive |-> (dout == '0));
endmodule

// File: rtl/xcvr_section.sv
module xcvr_section
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dir_ctrl_t        ab_ctrl,
  input  dir_ctrl_t        ba_ctrl,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic [WIDTH-1:0] b_out,
  output logic             a_drive,
  output logic             b_drive
);
  xcvr_path #(.WIDTH(WIDTH)) u_ab (
    .clk(clk), .rst_n(rst_n), .ctrl(ab_ctrl),
    .din(a_in), .dout(b_out), .drive(b_drive)
  );

  xcvr_path #(.WIDTH(WIDTH)) u_ba (
    .clk(clk), .rst_n(rst_n), .ctrl(ba_ctrl),
    .din(b_in), .dout(a_out), .drive(a_drive)
  );
endmodule

// File: rtl/dual_latch_xcvr.sv
module dual_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int SECTIONS = 2,
  parameter int WIDTH    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [SECTIONS*WIDTH-1:0] a_in,
  input  logic [SECTIONS*WIDTH-1:0] b_in,
  output logic [SECTIONS*WIDTH-1:0] a_out,
  output logic [SECTIONS*WIDTH-1:0] b_out,
  output logic [SECTIONS-1:0]       a_drive,
  output logic [SECTIONS-1:0]       b_drive,
  input  logic [SECTIONS-1:0]       ab_en_n,
  input  logic [SECTIONS-1:0]       ab_le_n,
  input  logic [SECTIONS-1:0]       ab_oe_n,
  input  logic [SECTIONS-1:0]       ba_en_n,
  input  logic [SECTIONS-1:0]       ba_le_n,
  input  logic [SECTIONS-1:0]       ba_oe_n
);
  localparam int BUS_W = SECTIONS * WIDTH;

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    dir_ctrl_t ab_c, ba_c;
    assign ab_c = '{en_n: ab_en_n[s], le_n: ab_le_n[s], oe_n: ab_oe_n[s]};
    assign ba_c = '{en_n: ba_en_n[s], le_n: ba_le_n[s], oe_n: ba_oe_n[s]};

    xcvr_section #(.WIDTH(WIDTH)) u_sec (
      .clk(clk), .rst_n(rst_n),
      .ab_ctrl(ab_c), .ba_ctrl(ba_c),
      .a_in(a_in[s*WIDTH +: WIDTH]), .b_in(b_in[s*WIDTH +: WIDTH]),
      .a_out(a_out[s*WIDTH +: WIDTH]), .b_out(b_out[s*WIDTH +: WIDTH]),
      .a_drive(a_drive[s]), .b_drive(b_drive[s])
    );
  end

  // R8
  reset_release_chk: assert property (@(posedge clk)
    !rst_n |-> (a_drive == '0 && b_drive == '0));

  // R9
  bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_drive == '0) |-> (b_out == {BUS_W{1'b0}}));
endmodule

// File: tb/dual_latch_xcvr_test.sv
module dual_latch_xcvr_test;
  localparam int CLK_PERIOD = 10;
  localparam int S = 2;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [S*W-1:0] a_in = '0, b_in = '0;
  logic [S*W-1:0] a_out, b_out;
  logic [S-1:0] a_drive, b_drive;
  logic [S-1:0] ab_en_n = '1, ab_le_n = '1, ab_oe_n = '1;
  logic [S-1:0] ba_en_n = '1, ba_le_n = '1, ba_oe_n = '1;

  int checks = 0;
  int failures = 0;
  int usage_err = 0;
  logic [W-1:0] m_ab [S];
  logic [W-1:0] m_ba [S];
  logic [31:0] seed = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_latch_xcvr #(.SECTIONS(S), .WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .a_drive(a_drive), .b_drive(b_drive),
    .ab_en_n(ab_en_n), .ab_le_n(ab_le_n), .ab_oe_n(ab_oe_n),
    .ba_en_n(ba_en_n), .ba_le_n(ba_le_n), .ba_oe_n(ba_oe_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check_all();
    for (int s = 0; s < S; s++) begin
      logic tr_ab, dr_ab, tr_ba, dr_ba;
      logic [W-1:0] e_b, e_a;
      tr_ab = !ab_en_n[s] && !ab_le_n[s];
      dr_ab = !ab_oe_n[s] && !ab_en_n[s];
      tr_ba = !ba_en_n[s] && !ba_le_n[s];
      dr_ba = !ba_oe_n[s] && !ba_en_n[s];
      e_b = dr_ab ? (tr_ab ? a_in[s*W +: W] : m_ab[s]) : '0;
      e_a = dr_ba ? (tr_ba ? b_in[s*W +: W] : m_ba[s]) : '0;
      if (tr_ab && dr_ab && tr_ba && dr_ba) usage_err++;
      chk(b_drive[s] == dr_ab, "R5 b_drive", 32'(b_drive[s]), 32'(dr_ab));
      chk(a_drive[s] == dr_ba, "R5 a_drive", 32'(a_drive[s]), 32'(dr_ba));
      chk(b_out[s*W +: W] == e_b, "R2/R3/R4/R9 b_out", 32'(b_out[s*W +: W]), 32'(e_b));
      chk(a_out[s*W +: W] == e_a, "R2/R3/R4/R9 a_out", 32'(a_out[s*W +: W]), 32'(e_a));
    end
  endtask

  // Inputs are applied just after a falling edge; check, take a rising edge, update model.
  task automatic tick();
    #1 check_all();
    @(posedge clk);
    for (int s = 0; s < S; s++) begin
      if (!ab_en_n[s] && !ab_le_n[s]) m_ab[s] = a_in[s*W +: W];
      if (!ba_en_n[s] && !ba_le_n[s]) m_ba[s] = b_in[s*W +: W];
    end
    @(negedge clk);
  endtask

  task automatic avoid_clash();
    for (int s = 0; s < S; s++)
      if (!ab_en_n[s] && !ab_le_n[s] && !ab_oe_n[s] &&
          !ba_en_n[s] && !ba_le_n[s] && !ba_oe_n[s]) ba_le_n[s] = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < S; s++) begin m_ab[s] = '0; m_ba[s] = '0; end
    // R8: drive flags stay low during reset even with enables asserted
    ab_en_n = '0; ab_oe_n = '0; ba_en_n = '0; ba_oe_n = '0;
    a_in = 16'hA5A5; b_in = 16'h3C3C;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(a_drive == '0 && b_drive == '0, "R8 drive in reset", 32'({a_drive, b_drive}), 0);
    chk(a_out == '0 && b_out == '0, "R8 data in reset", 32'({a_out, b_out}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: banks read zero after reset (hold mode, driving)
    ab_le_n = '1; ba_le_n = '1;
    #1;
    chk(b_out == '0 && b_drive == '1, "R8 cleared ab bank", 32'(b_out), 0);
    chk(a_out == '0 && a_drive == '1, "R8 cleared ba bank", 32'(a_out), 0);
    tick();

    // R6: capture while released, then display
    ab_oe_n[0] = 1'b1; ab_en_n[0] = 1'b0; ab_le_n[0] = 1'b0; a_in[7:0] = 8'h5A;
    #1 chk(b_drive[0] == 1'b0 && b_out[7:0] == 8'h00, "R6 released while loading", 32'(b_out[7:0]), 0);
    tick();
    ab_le_n[0] = 1'b1; a_in[7:0] = 8'h11;
    tick();
    ab_oe_n[0] = 1'b0;
    #1 chk(b_out[7:0] == 8'h5A && b_drive[0], "R6 captured shown", 32'(b_out[7:0]), 32'h5A);
    tick();

    // R7: the other direction holds a different byte
    ba_oe_n[0] = 1'b1; ba_en_n[0] = 1'b0; ba_le_n[0] = 1'b0; b_in[7:0] = 8'hC3;
    tick();
    ba_le_n[0] = 1'b1; ba_oe_n[0] = 1'b0; b_in[7:0] = 8'h00;
    #1 chk(a_out[7:0] == 8'hC3, "R7 ba bank", 32'(a_out[7:0]), 32'hC3);
    chk(b_out[7:0] == 8'h5A, "R7 ab bank", 32'(b_out[7:0]), 32'h5A);
    tick();

    // R3: capture through a rising enable with latch enable still low
    ab_le_n[1] = 1'b0; ab_en_n[1] = 1'b0; ab_oe_n[1] = 1'b0; a_in[15:8] = 8'h77;
    tick();
    ab_en_n[1] = 1'b1; a_in[15:8] = 8'h99;
    tick();
    ab_en_n[1] = 1'b0; ab_le_n[1] = 1'b1; a_in[15:8] = 8'h22;
    #1 chk(b_out[15:8] == 8'h77, "R3 enable-edge capture", 32'(b_out[15:8]), 32'h77);
    tick();

    // R1: a busy section 1 leaves section 0 untouched
    for (int i = 0; i < 8; i++) begin
      ab_en_n[1] = i[0]; ab_le_n[1] = i[1]; ab_oe_n[1] = i[2];
      ba_le_n[1] = 1'b1;
      a_in[15:8] = 8'(i * 37); b_in[15:8] = 8'(i * 53);
      #1 chk(b_out[7:0] == 8'h5A && a_out[7:0] == 8'hC3, "R1 section isolation",
             32'({a_out[7:0], b_out[7:0]}), 32'hC35A);
      tick();
    end

    // R2/R4/R5: full sweep of the six controls per section
    for (int c = 0; c < 64; c++) begin
      for (int s = 0; s < S; s++) begin
        ab_en_n[s] = c[0]; ab_le_n[s] = c[1]; ab_oe_n[s] = c[2];
        ba_en_n[s] = c[3]; ba_le_n[s] = c[4]; ba_oe_n[s] = c[5];
      end
      a_in = 16'(c * 16'h0301 + 16'h1020);
      b_in = 16'(c * 16'h0507 + 16'h4003);
      avoid_clash();
      tick();
      tick();
    end

    // pseudo-random histories
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = rnd();
      {ab_en_n, ab_le_n, ab_oe_n, ba_en_n, ba_le_n, ba_oe_n} = r[11:0];
      a_in = r[27:12] ^ 16'(i);
      b_in = rnd();
      avoid_clash();
      tick();
    end

    chk(usage_err == 0, "R7 no dual transparent drive", 32'(usage_err), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule